// File: doc/BRIEF.md
# Write Enable and Block Protection Unit

This unit sits between the serial command decoder of a small serial memory and its write sequencer. It keeps the write enable latch and the 3-bit protection code, and it answers two questions: may the byte at the current address be programmed, and may a pending status update be committed. The command decoder gives it one-cycle strobes for the enable, disable and status-write commands. It also sees the chip-select level, the write-protect pin and the sequencer's busy flag.

All inputs are sampled on `clk`. The unit detects the rising edge of chip select and the falling edge of busy by itself. The enable command only arms the latch, and the latch is set when chip select next rises. A status write is captured during the frame and committed on that same rising edge. The sequencer starts its internal cycle from the `sr_commit` pulse. When busy later drops, the latch clears. `MEM_BYTES` selects the array size as a power of two from 256 to 4096, and the protected ranges scale with it.

Top module: `wprot_unit`

## Requirements
- R1: After reset, `status_byte` is 0x00, the write enable latch is clear, `wr_allow` is 0 and `sr_commit` is 0.
- R2: A `cmd_wren` strobe sets the latch only when `cs_n` next rises. `wr_allow` stays 0 for the rest of the frame in which the strobe arrived, and becomes 1 one cycle after the rise if the address is unprotected, `wp_n` is 1 and `seq_busy` is 0.
- R3: A `cmd_wrdi` strobe while not busy clears the latch, and also clears any armed enable.
- R4: A falling edge of `seq_busy` clears the latch. This is the end of a byte, page or status write cycle.
- R5: `status_byte[7:3]` always reads zero. A committed status write loads only `wrsr_data[2:0]` into `status_byte[2:0]`. The commit happens on the `cs_n` rise that ends the frame, and `sr_commit` pulses in the cycle the new value appears.
- R6: `addr_prot` is 1 exactly when the address lies in the range selected by the code. With S = MEM_BYTES: 0 protects nothing; 1, 2, 3 and 4 protect the first, second, third and fourth quarter of S; 5 protects the lower half; 6 protects the first page; 7 protects the last page. `wr_allow` is 0 for every protected address.
- R7: The page is 16 bytes when MEM_BYTES is 512 or less, and 32 bytes otherwise.
- R8: `wp_n` low forces `wr_allow` to 0 and blocks the capture of a status write.
- R9: If `wp_n` is low in any cycle between the capture of a status write and the `cs_n` rise, that status write is dropped. `sr_commit` does not pulse and the code is unchanged.
- R10: A status write issued while the latch is clear has no effect on `status_byte`.
- R11: While `seq_busy` is 1, `wr_allow` is 0, and enable, disable and status-write strobes are ignored.
- R12: `addr_prot` reflects the protection code whatever the state of the latch, so that reads can still consult it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, power-up state |
| cs_n | input | 1 | Chip select level, low during a frame |
| wp_n | input | 1 | Write-protect pin, low inhibits writes |
| seq_busy | input | 1 | Internal write cycle in progress |
| cmd_wren | input | 1 | Enable-write command strobe |
| cmd_wrdi | input | 1 | Disable-write command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe, data valid |
| wrsr_data | input | 8 | Status byte received with the status write |
| addr | input | AW | Target byte address, AW = log2(MEM_BYTES) |
| status_byte | output | 8 | Status register value |
| addr_prot | output | 1 | Address lies in the protected range |
| wr_allow | output | 1 | A byte write to `addr` may proceed |
| sr_commit | output | 1 | One-cycle pulse: status write committed |

## Verification
A latch armed too early shows at once as `wr_allow` rising inside the frame that carried the enable. A latch that fails to clear shows as `wr_allow` still high one cycle after busy falls or after a disable strobe. A corrupted protection code changes `status_byte` on the next cycle, and it also changes `addr_prot` across the whole address space. The bench therefore sweeps every code against every address of a 256-byte and a 1024-byte instance. A status write that escapes the write-protect abort shows as an `sr_commit` pulse and a changed code one cycle after chip select rises.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  localparam int unsigned MAX_AW = 12;

  typedef enum logic [2:0] {
    PZ_NONE       = 3'd0,
    PZ_Q0         = 3'd1,
    PZ_Q1         = 3'd2,
    PZ_Q2         = 3'd3,
    PZ_Q3         = 3'd4,
    PZ_LOWER_HALF = 3'd5,
    PZ_HEAD_PAGE  = 3'd6,
    PZ_TAIL_PAGE  = 3'd7
  } prot_zone_e;

  // page granule used by the head/tail page zones
  function automatic int unsigned page_bytes(input int unsigned size);
    return (size <= 512) ? 16 : 32;
  endfunction

  // 1 when address a falls inside the zone selected by code
  function automatic logic prot_hit(input logic [2:0] code,
                                    input logic [MAX_AW-1:0] a,
                                    input int unsigned size);
    int unsigned q;
    int unsigned ai;
    int unsigned pg;
    logic        hit;
    q   = size / 4;
    ai  = 32'(a);
    pg  = page_bytes(size);
    hit = 1'b0;
    case (prot_zone_e'(code))
      PZ_Q0:         hit = (ai < q);
      PZ_Q1:         hit = (ai >= q) && (ai < 2 * q);
      PZ_Q2:         hit = (ai >= 2 * q) && (ai < 3 * q);
      PZ_Q3:         hit = (ai >= 3 * q);
      PZ_LOWER_HALF: hit = (ai < 2 * q);
      PZ_HEAD_PAGE:  hit = (ai < pg);
      PZ_TAIL_PAGE:  hit = (ai >= size - pg);
      default:       hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/wprot_edges.sv
module wprot_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic busy,
  output logic cs_rise,
  output logic busy_fall
);
  logic cs_q;
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      busy_q <= busy;
    end
  end

  assign cs_rise   = cs_n & ~cs_q;
  assign busy_fall = busy_q & ~busy;
endmodule

// File: rtl/wprot_wel.sv
module wprot_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wren,
  input  logic cmd_wrdi,
  input  logic busy,
  input  logic cs_rise,
  input  logic busy_fall,
  output logic wel
);
  logic arm_q;
  logic wel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      wel_q <= 1'b0;
    end else if (cmd_wrdi && !busy) begin
      arm_q <= 1'b0;
      wel_q <= 1'b0;
    end else begin
      // end of an internal cycle outranks a concurrent frame end
      if (busy_fall)             wel_q <= 1'b0;
      else if (cs_rise && arm_q) wel_q <= 1'b1;
      if (cs_rise)               arm_q <= 1'b0;
      else if (cmd_wren && !busy) arm_q <= 1'b1;
    end
  end

  assign wel = wel_q;
endmodule

// File: rtl/wprot_status.sv
module wprot_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wrsr,
  input  logic [7:0] wrsr_data,
  input  logic       wel,
  input  logic       wp_n,
  input  logic       busy,
  input  logic       cs_rise,
  output logic [7:0] status_byte,
  output logic       sr_commit
);
  localparam logic [7:0] CODE_MASK = 8'h07;

  logic       pend_v;
  logic [7:0] pend_d;
  logic [7:0] sr_q;
  logic       commit_q;
  logic       commit_go;

  assign commit_go = cs_rise & pend_v & wel & wp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_d   <= 8'h00;
      sr_q     <= 8'h00;
      commit_q <= 1'b0;
    end else begin
      commit_q <= commit_go;
      if (commit_go) sr_q <= pend_d & CODE_MASK;
      if (cs_rise || !wp_n) begin
        pend_v <= 1'b0;
      end else if (cmd_wrsr && wel && wp_n && !busy) begin
        pend_v <= 1'b1;
        pend_d <= wrsr_data;
      end
    end
  end

  assign status_byte = sr_q;
  assign sr_commit   = commit_q;
endmodule

// File: rtl/wprot_range.sv
module wprot_range #(
  parameter int unsigned MEM_BYTES = 256,
  localparam int unsigned AW = $clog2(MEM_BYTES)
) (
  input  logic [2:0]    code,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  assign hit = wprot_pkg::prot_hit(code, wprot_pkg::MAX_AW'(addr), MEM_BYTES);
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit #(
  parameter int unsigned MEM_BYTES = 256,
  localparam int unsigned AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wp_n,
  input  logic          seq_busy,
  input  logic          cmd_wren,
  input  logic          cmd_wrdi,
  input  logic          cmd_wrsr,
  input  logic [7:0]    wrsr_data,
  input  logic [AW-1:0] addr,
  output logic [7:0]    status_byte,
  output logic          addr_prot,
  output logic          wr_allow,
  output logic          sr_commit
);
  // named internal events, observed by the bound checker
  logic cs_rise;
  logic busy_fall;
  logic wel;

  wprot_edges u_edges (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(seq_busy),
    .cs_rise(cs_rise), .busy_fall(busy_fall)
  );

  wprot_wel u_wel (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .busy(seq_busy), .cs_rise(cs_rise), .busy_fall(busy_fall), .wel(wel)
  );

  wprot_status u_status (
    .clk(clk), .rst_n(rst_n), .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data),
    .wel(wel), .wp_n(wp_n), .busy(seq_busy), .cs_rise(cs_rise),
    .status_byte(status_byte), .sr_commit(sr_commit)
  );

  wprot_range #(.MEM_BYTES(MEM_BYTES)) u_range (
    .code(status_byte[2:0]), .addr(addr), .hit(addr_prot)
  );

  assign wr_allow = wel & wp_n & ~seq_busy & ~addr_prot;
endmodule

// File: rtl/wprot_unit_chk.sv
module wprot_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       seq_busy,
  input logic       cmd_wrdi,
  input logic       cs_rise,
  input logic       busy_fall,
  input logic       wel,
  input logic [7:0] status_byte,
  input logic       wr_allow,
  input logic       sr_commit
);
  p_arm_on_csrise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise));

  p_wrdi_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrdi && !seq_busy) |=> !wel);

  p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_fall |=> !wel);

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[7:3] == 5'b00000);

  p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |-> !wr_allow);

  p_commit_wp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_commit |-> $past(wp_n));

  p_commit_wel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sr_commit |-> $past(wel));

  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_commit |-> $stable(status_byte));

  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> !wr_allow);
endmodule

bind wprot_unit wprot_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .seq_busy(seq_busy),
  .cmd_wrdi(cmd_wrdi), .cs_rise(cs_rise), .busy_fall(busy_fall), .wel(wel),
  .status_byte(status_byte), .wr_allow(wr_allow), .sr_commit(sr_commit)
);

// File: tb/wprot_unit_tb.sv
module wprot_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       wp_n = 1'b1;
  logic       seq_busy = 1'b0;
  logic       cmd_wren = 1'b0;
  logic       cmd_wrdi = 1'b0;
  logic       cmd_wrsr = 1'b0;
  logic [7:0] wrsr_data = 8'h00;
  logic [7:0] addr_s = 8'h00;
  logic [9:0] addr_b = 10'h000;

  logic [7:0] st_s, st_b;
  logic       prot_s, prot_b, allow_s, allow_b, com_s, com_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wprot_unit #(.MEM_BYTES(256)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .seq_busy(seq_busy),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .wrsr_data(wrsr_data), .addr(addr_s), .status_byte(st_s),
    .addr_prot(prot_s), .wr_allow(allow_s), .sr_commit(com_s)
  );

  wprot_unit #(.MEM_BYTES(1024)) u_big (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .seq_busy(seq_busy),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .wrsr_data(wrsr_data), .addr(addr_b), .status_byte(st_b),
    .addr_prot(prot_b), .wr_allow(allow_b), .sr_commit(com_b)
  );

  // expected protection: explicit inclusive bounds per code
  function automatic bit exp_prot(int code, int a, int size);
    int pg;
    int lo;
    int hi;
    pg = (size > 512) ? 32 : 16;
    lo = 1;
    hi = 0;
    case (code)
      1: begin lo = 0;            hi = size / 4 - 1;     end
      2: begin lo = size / 4;     hi = size / 2 - 1;     end
      3: begin lo = size / 2;     hi = 3 * size / 4 - 1; end
      4: begin lo = 3 * size / 4; hi = size - 1;         end
      5: begin lo = 0;            hi = size / 2 - 1;     end
      6: begin lo = 0;            hi = pg - 1;           end
      7: begin lo = size - pg;    hi = size - 1;         end
      default: begin lo = 1; hi = 0; end
    endcase
    return (a >= lo) && (a <= hi);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
  endtask

  task automatic cs_high();
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobe_wren();
    @(negedge clk) cmd_wren = 1'b1;
    @(negedge clk) cmd_wren = 1'b0;
  endtask

  task automatic strobe_wrdi();
    @(negedge clk) cmd_wrdi = 1'b1;
    @(negedge clk) cmd_wrdi = 1'b0;
  endtask

  task automatic strobe_wrsr(input logic [7:0] d);
    @(negedge clk) begin cmd_wrsr = 1'b1; wrsr_data = d; end
    @(negedge clk) cmd_wrsr = 1'b0;
  endtask

  task automatic frame_wren();
    cs_low(); strobe_wren(); cs_high();
  endtask

  task automatic frame_wrdi();
    cs_low(); strobe_wrdi(); cs_high();
  endtask

  task automatic busy_cycle();
    @(negedge clk) seq_busy = 1'b1;
    @(negedge clk) seq_busy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 power-up state
    chk("R1 status", st_s, 8'h00);
    chk("R1 wr_allow", allow_s, 0);
    chk("R1 sr_commit", com_s, 0);

    // R2 enable arms only at the chip-select rise
    cs_low();
    strobe_wren();
    @(negedge clk);
    chk("R2 same frame", allow_s, 0);
    cs_high();
    chk("R2 after cs rise", allow_s, 1);

    // R3 disable clears
    frame_wrdi();
    chk("R3 after wrdi", allow_s, 0);

    // R8 write-protect pin gates writes
    frame_wren();
    @(negedge clk) wp_n = 1'b0;
    #1 chk("R8 wp low", allow_s, 0);
    @(negedge clk) wp_n = 1'b1;
    #1 chk("R8 wp high", allow_s, 1);

    // R11 busy gates, R4 busy fall clears the latch
    @(negedge clk) seq_busy = 1'b1;
    #1 chk("R11 busy gates", allow_s, 0);
    @(negedge clk) seq_busy = 1'b0;
    @(negedge clk);
    chk("R4 cleared at busy fall", allow_s, 0);

    // R10 status write without the latch
    cs_low(); strobe_wrsr(8'h05); cs_high();
    chk("R10 status unchanged", st_s, 8'h00);
    chk("R10 no commit", com_s, 0);

    // R9 write-protect abort of a pending status write
    frame_wren();
    cs_low();
    strobe_wrsr(8'h05);
    @(negedge clk) wp_n = 1'b0;
    @(negedge clk) wp_n = 1'b1;
    cs_high();
    chk("R9 no commit", com_s, 0);
    chk("R9 status unchanged", st_s, 8'h00);
    frame_wrdi();

    // R11 enable strobe during busy is ignored
    @(negedge clk) seq_busy = 1'b1;
    cs_low();
    strobe_wren();
    @(negedge clk) seq_busy = 1'b0;
    @(negedge clk);
    cs_high();
    chk("R11 wren ignored while busy", allow_s, 0);

    // R5 R6 R7 R12 sweep of every code over both sizes
    for (int c = 0; c < 8; c++) begin
      frame_wren();
      cs_low();
      strobe_wrsr(8'hA8 | 8'(c));
      cs_high();
      chk("R5 commit pulse", com_s, 1);
      chk("R5 status value", st_s, c);
      chk("R5 status value big", st_b, c);
      busy_cycle();
      for (int a = 0; a < 1024; a++) begin
        addr_b = 10'(a);
        if (a < 256) addr_s = 8'(a);
        #1;
        chk("R7 R12 prot big, latch clear", prot_b, int'(exp_prot(c, a, 1024)));
        chk("R4 allow big, latch clear", allow_b, 0);
        if (a < 256)
          chk("R6 R12 prot small, latch clear", prot_s, int'(exp_prot(c, a, 256)));
      end
      frame_wren();
      for (int a = 0; a < 1024; a++) begin
        addr_b = 10'(a);
        if (a < 256) addr_s = 8'(a);
        #1;
        chk("R6 R7 allow big", allow_b, int'(!exp_prot(c, a, 1024)));
        if (a < 256)
          chk("R6 allow small", allow_s, int'(!exp_prot(c, a, 256)));
      end
      frame_wrdi();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule